// File: doc/BRIEF.md
# SPI Slave Memory Access Bridge

This block lets an external SPI host (mode 0: clock idles low, data sampled on the rising edge, changed on the falling edge) read and write a little-endian internal memory with 32-bit byte addresses. A transaction opens when chip select falls. The host sends one command byte and then a four-byte address. Data follows, in words of 2, 4 or 8 bytes as the command selects. The bridge drives a simple synchronous memory port with byte enables and carries no other state between transactions.

The serial pins are oversampled by the system clock through short synchronizer chains, so SCLK must be several times slower than the system clock. Each wire word travels most significant byte first. The bridge maps the first wire byte of a word to the highest address of that word, so the memory sees a little-endian word. A read has four dummy bytes after the address, and the bridge uses them to prefetch the first word. A write is closed by one dummy byte. A burst moves successive 8-byte words until chip select rises.

Top module: `spi_mem_bridge`

## Requirements
- R1: While reset is asserted, and once chip select has been high for a few system clocks, `spi_miso` is 0 and `mem_req` is 0.
- R2: Each transaction starts with a command byte and then a 32-bit byte address, each sent MSB first. Command codes are 0x00 read-16, 0x01 write-16, 0x02 read-32, 0x03 write-32, 0x04 read-burst and 0x05 write-burst.
- R3: For write-16 and write-32, one memory write is issued once 2 or 4 data bytes have been received. It goes to the header address with `mem_be` 0x03 or 0x0F. Lane i (`mem_wdata` bits 8i+7..8i, byte at address+i) holds data byte W-1-i in wire order, where W is the word size. Any further bytes before chip select rises cause no write.
- R4: For write-burst, every 8 received data bytes produce one write with `mem_be` 0xFF. Word n goes to header address + 8n, and its lanes are ordered as in R3 with W=8.
- R5: For read commands, MISO is 0 during the four dummy bytes after the address. The word is then sent MSB first, and wire byte b is the memory byte at address + W-1-b. `mem_rdata` lane i is the byte at `mem_addr`+i, valid in the cycle after the read request.
- R6: For read-burst, successive 8-byte words come from header address + 8n for as long as the host clocks, up to 240 data bytes.
- R7: For read-16 and read-32, MISO is 0 after the single data word until chip select rises.
- R8: A command byte above 0x05 causes no memory write, and MISO stays 0 for the whole transaction.
- R9: A data word left incomplete when chip select rises is not written.
- R10: Raising chip select in the middle of a header abandons that transaction. The next falling edge of chip select starts a fresh header.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, also used to oversample the SPI pins |
| rst_n | input | 1 | Active-low synchronous reset |
| spi_sclk | input | 1 | SPI serial clock from host, mode 0 |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host, 0 when not sending read data |
| mem_req | output | 1 | One-cycle memory access request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | 32 | Byte address of lane 0 |
| mem_be | output | 8 | Byte-lane enables |
| mem_wdata | output | 64 | Write data, lane i = byte at mem_addr+i |
| mem_rdata | input | 64 | Read data, valid the cycle after a read request |

## Verification
The bench writes words of every size, at aligned and misaligned addresses, and reads them back. A bridge that failed to reverse bytes, or reversed them across the wrong word width, would return the bytes swapped or would put a 16-bit word on the wrong lanes. It also runs a full 240-byte burst, clocks extra bytes after 16- and 32-bit words, and ends a burst in the middle of a word. A design that got these wrong would write past the word, send stale data after the word, or commit garbage from a partial word. Unknown command codes and a header cut short by chip select check that nothing leaks to memory or MISO, and that framing restarts cleanly on the next chip select.

// File: rtl/spi_mem_bridge_pkg.sv
package spi_mem_bridge_pkg;

    localparam int CMD_BITS      = 8;
    localparam int RD_DUMMY_BITS = 32;
    localparam logic [CMD_BITS-1:0] CMD_LAST_VALID = 8'h05;

    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_e;

    typedef enum logic [1:0] {
        SZ_16    = 2'd0,
        SZ_32    = 2'd1,
        SZ_BURST = 2'd2
    } size_e;

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic cs_n,
    input  logic mosi,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_active,
    output logic mosi_s
);

    localparam int NPIN = 3;
    // pin order: [2] sclk, [1] cs_n, [0] mosi; chip select resets inactive
    localparam logic [NPIN-1:0] RST_VAL = 3'b010;

    logic [NPIN-1:0] pins_in;
    logic [NPIN-1:0] pins_s;
    logic            sclk_prev_q;

    assign pins_in = {sclk, cs_n, mosi};

    for (genvar p = 0; p < NPIN; p++) begin : g_sync
        logic [STAGES-1:0] chain_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain_q <= {STAGES{RST_VAL[p]}};
            end else begin
                chain_q <= {chain_q[STAGES-2:0], pins_in[p]};
            end
        end
        assign pins_s[p] = chain_q[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_prev_q <= 1'b0;
        end else begin
            sclk_prev_q <= pins_s[2];
        end
    end

    assign sclk_rise = pins_s[2] & ~sclk_prev_q;
    assign sclk_fall = ~pins_s[2] & sclk_prev_q;
    assign cs_active = ~pins_s[1];
    assign mosi_s    = pins_s[0];

endmodule

// File: rtl/spi_bridge_ctrl.sv
module spi_bridge_ctrl
    import spi_mem_bridge_pkg::*;
#(
    parameter int ADDR_W          = 32,
    parameter int DATA_BYTES      = 8,
    parameter int MAX_BURST_BYTES = 240
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sclk_rise,
    input  logic                    sclk_fall,
    input  logic                    cs_active,
    input  logic                    mosi_s,
    output logic                    miso,
    output logic                    mem_req,
    output logic                    mem_we,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic [DATA_BYTES-1:0]   mem_be,
    output logic [DATA_BYTES*8-1:0] mem_wdata,
    input  logic [DATA_BYTES*8-1:0] mem_rdata
);

    localparam int DATA_W    = DATA_BYTES * 8;
    localparam int HDR_BITS  = CMD_BITS + ADDR_W;
    localparam int RD_START  = HDR_BITS + RD_DUMMY_BITS;
    localparam int CNT_MAX_I = RD_START + MAX_BURST_BYTES * 8 + DATA_W;
    localparam int CNT_W     = $clog2(CNT_MAX_I + 1);

    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(CNT_MAX_I);
    localparam logic [CNT_W-1:0] CMD_C    = CNT_W'(CMD_BITS);
    localparam logic [CNT_W-1:0] HDR_C    = CNT_W'(HDR_BITS);
    localparam logic [CNT_W-1:0] HDR_LAST = CNT_W'(HDR_BITS - 1);
    localparam logic [CNT_W-1:0] RD_C     = CNT_W'(RD_START);
    localparam logic [ADDR_W-1:0] STRIDE  = ADDR_W'(DATA_BYTES);

    localparam logic [DATA_BYTES-1:0] BE_16    = {{(DATA_BYTES-2){1'b0}}, 2'b11};
    localparam logic [DATA_BYTES-1:0] BE_32    = {{(DATA_BYTES-4){1'b0}}, 4'hF};
    localparam logic [DATA_BYTES-1:0] BE_BURST = '1;

    typedef struct packed {
        logic [CNT_W-1:0]      cnt;
        logic [CMD_BITS-1:0]   cmd;
        logic [ADDR_W-1:0]     addr;
        acc_e                  acc;
        size_e                 size;
        logic [DATA_W-1:0]     rx_sr;
        logic [DATA_W-1:0]     tx_sr;
        logic [DATA_W-1:0]     rbuf;
        logic                  rd_pend;
        logic                  miso;
        logic                  req;
        logic                  we;
        logic [ADDR_W-1:0]     maddr;
        logic [DATA_W-1:0]     wdata;
        logic [DATA_BYTES-1:0] be;
    } st_t;

    st_t st_d, st_q;

    function automatic logic [DATA_BYTES-1:0] be_of(size_e s);
        case (s)
            SZ_16:   return BE_16;
            SZ_32:   return BE_32;
            default: return BE_BURST;
        endcase
    endfunction

    function automatic logic [CNT_W-1:0] bits_of(size_e s);
        case (s)
            SZ_16:   return CNT_W'(16);
            SZ_32:   return CNT_W'(32);
            default: return CNT_W'(DATA_W);
        endcase
    endfunction

    always_comb begin
        logic [DATA_W-1:0]     rx_next;
        logic [DATA_W-1:0]     word;
        logic [CNT_W-1:0]      wbits;
        logic [CNT_W-1:0]      k;
        logic [CNT_W-1:0]      pos;
        logic [DATA_BYTES-1:0] be;
        logic [ADDR_W-1:0]     hdr_addr;
        size_e                 hdr_size;

        st_d         = st_q;
        st_d.req     = 1'b0;
        st_d.rd_pend = st_q.req & ~st_q.we;
        if (st_q.rd_pend) begin
            st_d.rbuf = mem_rdata;
        end

        wbits    = bits_of(st_q.size);
        be       = be_of(st_q.size);
        rx_next  = {st_q.rx_sr[DATA_W-2:0], mosi_s};
        hdr_addr = {st_q.addr[ADDR_W-2:0], mosi_s};
        hdr_size = size_e'(st_q.cmd[2:1]);
        k        = '0;
        pos      = '0;
        word     = '0;

        if (!cs_active) begin
            st_d.cnt  = '0;
            st_d.cmd  = '0;
            st_d.acc  = ACC_NONE;
            st_d.miso = 1'b0;
        end else begin
            if (sclk_rise) begin
                st_d.rx_sr = rx_next;
                if (st_q.cnt != CNT_MAX) begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
                if (st_q.cnt < CMD_C) begin
                    st_d.cmd = {st_q.cmd[CMD_BITS-2:0], mosi_s};
                end else if (st_q.cnt < HDR_C) begin
                    st_d.addr = hdr_addr;
                end
                if (st_q.cnt == HDR_LAST) begin
                    st_d.size = hdr_size;
                    if (st_q.cmd > CMD_LAST_VALID) begin
                        st_d.acc = ACC_NONE;
                    end else if (st_q.cmd[0]) begin
                        st_d.acc = ACC_WRITE;
                    end else begin
                        st_d.acc   = ACC_READ;
                        st_d.req   = 1'b1;
                        st_d.we    = 1'b0;
                        st_d.maddr = hdr_addr;
                        st_d.be    = be_of(hdr_size);
                        st_d.addr  = hdr_addr + STRIDE;
                    end
                end
                if (st_q.acc == ACC_WRITE && st_q.cnt >= HDR_C) begin
                    k   = st_q.cnt - HDR_C;
                    pos = k & (wbits - 1'b1);
                    if (pos == wbits - 1'b1 && (st_q.size == SZ_BURST || k < wbits)) begin
                        st_d.req   = 1'b1;
                        st_d.we    = 1'b1;
                        st_d.maddr = st_q.addr;
                        st_d.be    = be;
                        st_d.addr  = st_q.addr + STRIDE;
                        for (int i = 0; i < DATA_BYTES; i++) begin
                            st_d.wdata[8*i +: 8] = be[i] ? rx_next[8*i +: 8] : 8'h00;
                        end
                    end
                end
            end
            if (sclk_fall && st_q.acc == ACC_READ && st_q.cnt >= RD_C) begin
                k   = st_q.cnt - RD_C;
                pos = k & (wbits - 1'b1);
                if (st_q.size != SZ_BURST && k >= wbits) begin
                    st_d.miso = 1'b0;
                end else if (pos == '0) begin
                    word       = st_q.rbuf << (CNT_W'(DATA_W) - wbits);
                    st_d.miso  = word[DATA_W-1];
                    st_d.tx_sr = word << 1;
                    if (st_q.size == SZ_BURST) begin
                        st_d.req   = 1'b1;
                        st_d.we    = 1'b0;
                        st_d.maddr = st_q.addr;
                        st_d.be    = BE_BURST;
                        st_d.addr  = st_q.addr + STRIDE;
                    end
                end else begin
                    st_d.miso  = st_q.tx_sr[DATA_W-1];
                    st_d.tx_sr = st_q.tx_sr << 1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign miso      = st_q.miso;
    assign mem_req   = st_q.req;
    assign mem_we    = st_q.we;
    assign mem_addr  = st_q.maddr;
    assign mem_be    = st_q.be;
    assign mem_wdata = st_q.wdata;

endmodule

// File: rtl/spi_mem_bridge.sv
module spi_mem_bridge #(
    parameter int ADDR_W          = 32,
    parameter int DATA_BYTES      = 8,
    parameter int MAX_BURST_BYTES = 240,
    parameter int SYNC_STAGES     = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    spi_sclk,
    input  logic                    spi_cs_n,
    input  logic                    spi_mosi,
    output logic                    spi_miso,
    output logic                    mem_req,
    output logic                    mem_we,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic [DATA_BYTES-1:0]   mem_be,
    output logic [DATA_BYTES*8-1:0] mem_wdata,
    input  logic [DATA_BYTES*8-1:0] mem_rdata
);

    logic sclk_rise;
    logic sclk_fall;
    logic cs_active;
    logic mosi_s;

    spi_pin_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk      (spi_sclk),
        .cs_n      (spi_cs_n),
        .mosi      (spi_mosi),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .cs_active (cs_active),
        .mosi_s    (mosi_s)
    );

    spi_bridge_ctrl #(
        .ADDR_W          (ADDR_W),
        .DATA_BYTES      (DATA_BYTES),
        .MAX_BURST_BYTES (MAX_BURST_BYTES)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .cs_active (cs_active),
        .mosi_s    (mosi_s),
        .miso      (spi_miso),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_be    (mem_be),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata)
    );

endmodule

// File: rtl/spi_mem_bridge_chk.sv
module spi_mem_bridge_chk #(
    parameter int DATA_BYTES = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  spi_sclk,
    input logic                  spi_cs_n,
    input logic                  spi_miso,
    input logic                  mem_req,
    input logic [DATA_BYTES-1:0] mem_be
);

    localparam logic [DATA_BYTES-1:0] BE_16 = {{(DATA_BYTES-2){1'b0}}, 2'b11};
    localparam logic [DATA_BYTES-1:0] BE_32 = {{(DATA_BYTES-4){1'b0}}, 4'hF};
    localparam logic [DATA_BYTES-1:0] BE_64 = '1;
    localparam logic [2:0] IDLE_SETTLE = 3'd5;

    logic [2:0] idle_cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !spi_cs_n) begin
            idle_cnt_q <= '0;
        end else if (idle_cnt_q != 3'd7) begin
            idle_cnt_q <= idle_cnt_q + 1'b1;
        end
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (idle_cnt_q >= IDLE_SETTLE) |-> (!spi_miso && !mem_req)); // R1
    AST_BE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n) mem_req |-> (mem_be == BE_16 || mem_be == BE_32 || mem_be == BE_64)); // R3
    AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) mem_req |=> !mem_req); // R4
    AST_MISO_ON_LOW_SCLK: assert property (@(posedge clk) disable iff (!rst_n) !$stable(spi_miso) |-> !spi_sclk); // R5

endmodule

bind spi_mem_bridge spi_mem_bridge_chk #(
    .DATA_BYTES (DATA_BYTES)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .spi_sclk (spi_sclk),
    .spi_cs_n (spi_cs_n),
    .spi_miso (spi_miso),
    .mem_req  (mem_req),
    .mem_be   (mem_be)
);

// File: tb/spi_mem_bridge_bench.sv
`timescale 1ns/1ps
module spi_mem_bridge_bench;

    localparam int HALF = 24;
    localparam int WATCHDOG_CYCLES = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        spi_sclk = 1'b0;
    logic        spi_cs_n = 1'b1;
    logic        spi_mosi = 1'b0;
    logic        spi_miso;
    logic        mem_req;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [7:0]  mem_be;
    logic [63:0] mem_wdata;
    logic [63:0] mem_rdata = '0;
    logic [63:0] rd_tmp;

    int vectors = 0;
    int miscompares = 0;

    logic [7:0]  wbuf [0:255];
    logic [31:0] ea_q [$];
    logic [7:0]  eb_q [$];
    logic [63:0] ed_q [$];
    logic [7:0]  mem_model [int unsigned];
    logic [7:0]  ref_mem [int unsigned];

    always #2 clk = ~clk;

    spi_mem_bridge u_spi_mem_bridge (
        .clk       (clk),
        .rst_n     (rst_n),
        .spi_sclk  (spi_sclk),
        .spi_cs_n  (spi_cs_n),
        .spi_mosi  (spi_mosi),
        .spi_miso  (spi_miso),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_be    (mem_be),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata)
    );

    function automatic logic [7:0] dflt(logic [31:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    function automatic logic [7:0] model_get(logic [31:0] a);
        if (mem_model.exists(a)) return mem_model[a];
        return dflt(a);
    endfunction

    function automatic logic [7:0] ref_get(logic [31:0] a);
        if (ref_mem.exists(a)) return ref_mem[a];
        return dflt(a);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // memory model: one-cycle read latency, lane i = byte at mem_addr+i
    always @(posedge clk) begin
        if (rst_n && mem_req) begin
            if (mem_we) begin
                for (int i = 0; i < 8; i++) begin
                    if (mem_be[i]) mem_model[mem_addr + 32'(i)] = mem_wdata[8*i +: 8];
                end
            end else begin
                for (int i = 0; i < 8; i++) rd_tmp[8*i +: 8] = model_get(mem_addr + 32'(i));
                mem_rdata <= rd_tmp;
            end
        end
    end

    // per-clock comparison of the memory port against expected writes
    always @(negedge clk) begin
        if (rst_n && mem_req && mem_we) begin
            if (ea_q.size() == 0) begin
                chk(1'b0, "R8/R9", "unexpected write at", {32'h0, mem_addr}, 64'h0);
            end else begin
                logic [31:0] ea;
                logic [7:0]  eb;
                logic [63:0] ed;
                ea = ea_q.pop_front();
                eb = eb_q.pop_front();
                ed = ed_q.pop_front();
                chk(mem_addr == ea, "R2", "write address", {32'h0, mem_addr}, {32'h0, ea});
                chk(mem_be == eb, "R3/R4", "write byte enables", {56'h0, mem_be}, {56'h0, eb});
                chk(mem_wdata == ed, "R3/R4", "write data lanes", mem_wdata, ed);
            end
        end
    end

    task automatic sbyte(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            spi_mosi = tx[i];
            #HALF;
            rx[i] = spi_miso;
            spi_sclk = 1'b1;
            #HALF;
            spi_sclk = 1'b0;
        end
    endtask

    task automatic cs_low();
        spi_cs_n = 1'b0;
        #HALF;
    endtask

    task automatic cs_high();
        #HALF;
        spi_cs_n = 1'b1;
        #(HALF * 4);
    endtask

    task automatic send_hdr(input logic [7:0] cmd, input logic [31:0] addr);
        logic [7:0] rx;
        sbyte(cmd, rx);
        for (int i = 3; i >= 0; i--) sbyte(addr[8*i +: 8], rx);
    endtask

    task automatic do_write(input logic [7:0] cmd, input logic [31:0] addr, input int nbytes,
                            input bit dummy, input logic [7:0] seed, input string req);
        int wsz;
        bit burst;
        bit valid;
        int nwords;
        logic [7:0] rx;
        wsz   = (cmd[2:1] == 2'd0) ? 2 : (cmd[2:1] == 2'd1) ? 4 : 8;
        burst = (cmd[2:1] == 2'd2);
        valid = (cmd <= 8'h05) && cmd[0];
        for (int i = 0; i < nbytes; i++) wbuf[i] = seed + 8'(i * 13);
        nwords = 0;
        if (valid) nwords = burst ? nbytes / 8 : ((nbytes >= wsz) ? 1 : 0);
        for (int n = 0; n < nwords; n++) begin
            logic [31:0] wa;
            logic [7:0]  eb;
            logic [63:0] ed;
            wa = burst ? addr + 32'(8 * n) : addr;
            eb = 8'((1 << wsz) - 1);
            ed = '0;
            for (int i = 0; i < wsz; i++) begin
                ed[8*i +: 8] = wbuf[n * wsz + wsz - 1 - i];
                ref_mem[wa + 32'(i)] = wbuf[n * wsz + wsz - 1 - i];
            end
            ea_q.push_back(wa);
            eb_q.push_back(eb);
            ed_q.push_back(ed);
        end
        cs_low();
        send_hdr(cmd, addr);
        for (int i = 0; i < nbytes; i++) begin
            sbyte(wbuf[i], rx);
            if (!valid) chk(rx == 8'h00, req, "MISO during unknown command", {56'h0, rx}, 64'h0);
        end
        if (dummy) sbyte(8'h00, rx);
        cs_high();
        chk(ea_q.size() == 0, req, "writes still pending after chip select", 64'(ea_q.size()), 64'h0);
        chk(spi_miso == 1'b0, "R1", "MISO idle after transaction", {63'h0, spi_miso}, 64'h0);
    endtask

    task automatic do_read(input logic [7:0] cmd, input logic [31:0] addr, input int nbytes,
                           input string req);
        int wsz;
        bit burst;
        logic [7:0] rx;
        logic [7:0] exp;
        wsz   = (cmd[2:1] == 2'd0) ? 2 : (cmd[2:1] == 2'd1) ? 4 : 8;
        burst = (cmd[2:1] == 2'd2);
        cs_low();
        send_hdr(cmd, addr);
        for (int i = 0; i < 4; i++) begin
            sbyte(8'h00, rx);
            chk(rx == 8'h00, "R5", "MISO in read dummy byte", {56'h0, rx}, 64'h0);
        end
        for (int b = 0; b < nbytes; b++) begin
            sbyte(8'h00, rx);
            if (burst || b < wsz) begin
                int n;
                int j;
                n = b / wsz;
                j = b % wsz;
                exp = ref_get(addr + 32'(8 * n) + 32'(wsz - 1 - j));
            end else begin
                exp = 8'h00;
            end
            chk(rx == exp, req, $sformatf("read byte %0d at %h", b, addr), {56'h0, rx}, {56'h0, exp});
        end
        cs_high();
        chk(spi_miso == 1'b0, "R1", "MISO idle after read", {63'h0, spi_miso}, 64'h0);
    endtask

    initial begin
        logic [7:0] rx;
        #1;
        #40;
        chk(spi_miso == 1'b0 && mem_req == 1'b0, "R1", "outputs in reset",
            {62'h0, spi_miso, mem_req}, 64'h0);
        rst_n = 1'b1;
        #20;
        chk(spi_miso == 1'b0 && mem_req == 1'b0, "R1", "outputs after reset",
            {62'h0, spi_miso, mem_req}, 64'h0);

        do_write(8'h01, 32'h0000_0100, 2, 1'b1, 8'h11, "R3");
        do_write(8'h03, 32'h0000_0204, 4, 1'b1, 8'h21, "R3");
        do_write(8'h01, 32'h0000_0302, 2, 1'b1, 8'h31, "R3");
        do_write(8'h03, 32'h0000_0208, 8, 1'b1, 8'h41, "R3");
        do_write(8'h05, 32'h0000_1000, 24, 1'b1, 8'h51, "R4");

        do_read(8'h00, 32'h0000_0100, 2, "R5");
        do_read(8'h02, 32'h0000_0204, 4, "R5");
        do_read(8'h02, 32'h0000_0208, 8, "R7");
        do_read(8'h00, 32'h0000_0302, 4, "R7");
        do_read(8'h04, 32'h0000_1000, 24, "R6");
        do_read(8'h04, 32'h0050_0000, 16, "R6");

        do_write(8'h05, 32'h0000_2000, 240, 1'b1, 8'h61, "R6");
        do_read(8'h04, 32'h0000_2000, 240, "R6");

        do_write(8'h05, 32'h0000_3000, 11, 1'b0, 8'h71, "R9");
        do_read(8'h04, 32'h0000_3000, 16, "R9");

        do_write(8'h06, 32'h0000_1000, 8, 1'b1, 8'h81, "R8");
        do_write(8'hA5, 32'h0000_1008, 8, 1'b1, 8'h85, "R8");
        do_read(8'h04, 32'h0000_1000, 16, "R8");

        cs_low();
        sbyte(8'h05, rx);
        sbyte(8'h00, rx);
        cs_high();
        do_write(8'h01, 32'h0000_0400, 2, 1'b1, 8'h91, "R10");
        do_read(8'h00, 32'h0000_0400, 2, "R10");
        do_read(8'h02, 32'hC0DE_0104, 4, "R2");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #(WATCHDOG_CYCLES * 4);
        vectors++;
        miscompares++;
        $display("FAIL watchdog: run did not finish, actual %0d cycles expected fewer", WATCHDOG_CYCLES);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule